// File: doc/BRIEF.md
# Per-Slice Interrupt Register Bank

This block gathers interrupt events from sixteen serial slices and presents them to software through a small register bus. Events fall into four classes: shift clock (class 0), buffer swap (class 1), pattern match (class 2) and input bit match (class 3). Every class has its own sixteen-bit pending register, one bit per slice, and its own sixteen-bit enable mask. Bit n always belongs to slice n, so bit 0 is the first slice and bit 15 the last.

Software never writes the enable mask directly. One address turns mask bits on and another turns them off, so one driver can change its own slices without a read-modify-write. Pending bits capture events whether or not they are enabled, and they stay set until software acknowledges them. A force address sets pending bits by hand for testing. The interrupt request is high whenever any class has a bit that is both pending and enabled.

The register address is `{class[1:0], slot[2:0]}`. The slots are: 0 enable-set (write), 1 enable-clear (write), 2 enable view (read), 3 pending view (read), 4 pending force (write) and 5 pending acknowledge (write). Slots 6 and 7 are unmapped. Reads are combinational from the address. A write takes effect at the clock edge where the write strobe is sampled high.

Top module: `irq_slice_bank`

## Requirements
- R1: After a synchronous reset, every enable mask and every pending register reads 0, and the interrupt request is low.
- R2: Writing to slot 0 of a class sets each enable bit that is 1 in the write data, and leaves the bits written as 0 unchanged.
- R3: Writing to slot 1 of a class clears each enable bit that is 1 in the write data, and leaves the bits written as 0 unchanged.
- R4: A read of slot 2 returns the class's enable mask, with bit n belonging to slice n. For example, 0x0009 means slices 0 and 3 are enabled.
- R5: An event pulse on bit n of a class input sets pending bit n at the next edge, whether or not that bit is enabled. Several bits can be set in the same cycle. A pending bit stays set until it is acknowledged. A read of slot 3 returns the pending register.
- R6: Writing to slot 4 sets each pending bit that is 1 in the write data, the same way a real event would.
- R7: Writing to slot 5 clears each pending bit that is 1 in the write data, and leaves the other bits unchanged.
- R8: If an event and an acknowledge hit the same pending bit in the same cycle, the bit stays set.
- R9: The interrupt request is the OR, over all four classes, of pending AND enable. It follows register changes in the cycle after the edge that made them, so enabling a bit that is already pending raises the request.
- R10: A write to one class changes no enable or pending bit of any other class.
- R11: Writes to slots 6 and 7 change nothing. Reads of slots 0, 1, 4, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_shift_i | input | 16 | Shift-clock event pulses per slice (class 0) |
| evt_swap_i | input | 16 | Buffer-swap event pulses per slice (class 1) |
| evt_match_i | input | 16 | Pattern-match event pulses per slice (class 2) |
| evt_bitm_i | input | 16 | Input-bit-match event pulses per slice (class 3) |
| reg_addr_i | input | 5 | Register address {class, slot} |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the enable masks change only on a sampled write strobe, and that a pending bit falls only on a sampled write. They also assume that reset is applied at the first clock edge. The bench drives every input on the falling edge, holds each write strobe for exactly one cycle, and applies each event pulse for one cycle. It raises an event together with a write only in the collision scenario, where both target the same bit.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int SLICES     = 16;
    localparam int CLASSES    = 4;
    localparam int SLOT_BITS  = 3;
    localparam int CLASS_BITS = $clog2(CLASSES);
    localparam int ADDR_W     = CLASS_BITS + SLOT_BITS;

    typedef logic [SLICES-1:0] slice_mask_t;

    typedef enum logic [SLOT_BITS-1:0] {
        SLOT_ENA_SET    = 3'd0,
        SLOT_ENA_CLR    = 3'd1,
        SLOT_ENA_VIEW   = 3'd2,
        SLOT_PEND_VIEW  = 3'd3,
        SLOT_PEND_FORCE = 3'd4,
        SLOT_PEND_ACK   = 3'd5
    } slot_e;

    typedef struct packed {
        slice_mask_t ena_set;
        slice_mask_t ena_clr;
        slice_mask_t pend_force;
        slice_mask_t pend_ack;
    } class_wr_t;

    function automatic slice_mask_t gate_mask(input logic hit, input slice_mask_t data);
        return hit ? data : '0;
    endfunction

    function automatic slice_mask_t next_enable(input slice_mask_t cur,
                                                input slice_mask_t set_m,
                                                input slice_mask_t clr_m);
        return (cur | set_m) & ~clr_m;
    endfunction

    // Event and force are OR-ed in after the acknowledge, so they win over it.
    function automatic slice_mask_t next_pending(input slice_mask_t cur,
                                                 input slice_mask_t evt,
                                                 input slice_mask_t force_m,
                                                 input slice_mask_t ack_m);
        return (cur & ~ack_m) | evt | force_m;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_bank_pkg::*;
(
    input  logic [ADDR_W-1:0]               reg_addr_i,
    input  logic                            reg_wr_i,
    input  slice_mask_t                     reg_wdata_i,
    input  logic [CLASSES-1:0][SLICES-1:0]  en_vec_i,
    input  logic [CLASSES-1:0][SLICES-1:0]  st_vec_i,
    output class_wr_t [CLASSES-1:0]         wr_req_o,
    output slice_mask_t                     reg_rdata_o
);

    logic [CLASS_BITS-1:0] cls;
    logic [SLOT_BITS-1:0]  slot;

    assign cls  = reg_addr_i[ADDR_W-1:SLOT_BITS];
    assign slot = reg_addr_i[SLOT_BITS-1:0];

    always_comb begin
        for (int c = 0; c < CLASSES; c++) begin
            wr_req_o[c].ena_set    = gate_mask(reg_wr_i && cls == CLASS_BITS'(c) && slot == SLOT_ENA_SET,    reg_wdata_i);
            wr_req_o[c].ena_clr    = gate_mask(reg_wr_i && cls == CLASS_BITS'(c) && slot == SLOT_ENA_CLR,    reg_wdata_i);
            wr_req_o[c].pend_force = gate_mask(reg_wr_i && cls == CLASS_BITS'(c) && slot == SLOT_PEND_FORCE, reg_wdata_i);
            wr_req_o[c].pend_ack   = gate_mask(reg_wr_i && cls == CLASS_BITS'(c) && slot == SLOT_PEND_ACK,   reg_wdata_i);
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (slot == SLOT_ENA_VIEW) begin
            reg_rdata_o = en_vec_i[cls];
        end else if (slot == SLOT_PEND_VIEW) begin
            reg_rdata_o = st_vec_i[cls];
        end
    end

endmodule

// File: rtl/irq_class_bank.sv
module irq_class_bank
    import irq_bank_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  slice_mask_t evt_i,
    input  class_wr_t   wr_i,
    output slice_mask_t en_o,
    output slice_mask_t st_o
);

    slice_mask_t en_q;
    slice_mask_t st_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            en_q <= next_enable(en_q, wr_i.ena_set, wr_i.ena_clr);
            st_q <= next_pending(st_q, evt_i, wr_i.pend_force, wr_i.pend_ack);
        end
    end

    assign en_o = en_q;
    assign st_o = st_q;

endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import irq_bank_pkg::*;
(
    input  logic [CLASSES-1:0][SLICES-1:0] en_vec_i,
    input  logic [CLASSES-1:0][SLICES-1:0] st_vec_i,
    output logic                           irq_o
);

    logic [CLASSES-1:0] class_req;

    for (genvar c = 0; c < CLASSES; c++) begin : g_req
        assign class_req[c] = |(en_vec_i[c] & st_vec_i[c]);
    end

    assign irq_o = |class_req;

endmodule

// File: rtl/irq_slice_bank.sv
module irq_slice_bank
    import irq_bank_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [SLICES-1:0]    evt_shift_i,
    input  logic [SLICES-1:0]    evt_swap_i,
    input  logic [SLICES-1:0]    evt_match_i,
    input  logic [SLICES-1:0]    evt_bitm_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [SLICES-1:0]    reg_wdata_i,
    output logic [SLICES-1:0]    reg_rdata_o,
    output logic                 irq_o
);

    logic [CLASSES-1:0][SLICES-1:0] evt_vec;
    logic [CLASSES-1:0][SLICES-1:0] en_vec;
    logic [CLASSES-1:0][SLICES-1:0] st_vec;
    class_wr_t [CLASSES-1:0]        wr_req;

    assign evt_vec[0] = evt_shift_i;
    assign evt_vec[1] = evt_swap_i;
    assign evt_vec[2] = evt_match_i;
    assign evt_vec[3] = evt_bitm_i;

    irq_reg_decode i_decode (
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .en_vec_i    (en_vec),
        .st_vec_i    (st_vec),
        .wr_req_o    (wr_req),
        .reg_rdata_o (reg_rdata_o)
    );

    for (genvar c = 0; c < CLASSES; c++) begin : g_class
        irq_class_bank i_bank (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .evt_i (evt_vec[c]),
            .wr_i  (wr_req[c]),
            .en_o  (en_vec[c]),
            .st_o  (st_vec[c])
        );
    end

    irq_combine i_combine (
        .en_vec_i (en_vec),
        .st_vec_i (st_vec),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/irq_slice_bank_chk.sv
module irq_slice_bank_chk
    import irq_bank_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic                           reg_wr,
    input logic [SLICES-1:0]              reg_wdata,
    input logic [CLASSES-1:0][SLICES-1:0] evt_vec,
    input logic [CLASSES-1:0][SLICES-1:0] en_vec,
    input logic [CLASSES-1:0][SLICES-1:0] st_vec,
    input logic                           irq
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (en_vec == '0 && st_vec == '0 && !irq)); // R1

    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(en_vec)); // R10

    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ((st_vec & $past(st_vec)) == $past(st_vec))); // R5

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_vec != '0 && st_vec != '0)); // R9

    for (genvar c = 0; c < CLASSES; c++) begin : g_cls
        AST_SET_ENABLE: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr[ADDR_W-1:SLOT_BITS] == CLASS_BITS'(c) &&
             reg_addr[SLOT_BITS-1:0] == SLOT_ENA_SET)
            |=> ((en_vec[c] & $past(reg_wdata)) == $past(reg_wdata))); // R2

        AST_CLR_ENABLE: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr[ADDR_W-1:SLOT_BITS] == CLASS_BITS'(c) &&
             reg_addr[SLOT_BITS-1:0] == SLOT_ENA_CLR)
            |=> ((en_vec[c] & $past(reg_wdata)) == '0)); // R3

        AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (rst)
            (evt_vec[c] != '0) |=> ((st_vec[c] & $past(evt_vec[c])) == $past(evt_vec[c]))); // R8

        AST_FORCE_SETS: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr[ADDR_W-1:SLOT_BITS] == CLASS_BITS'(c) &&
             reg_addr[SLOT_BITS-1:0] == SLOT_PEND_FORCE)
            |=> ((st_vec[c] & $past(reg_wdata)) == $past(reg_wdata))); // R6
    end

endmodule

bind irq_slice_bank irq_slice_bank_chk i_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .reg_addr  (reg_addr_i),
    .reg_wr    (reg_wr_i),
    .reg_wdata (reg_wdata_i),
    .evt_vec   (evt_vec),
    .en_vec    (en_vec),
    .st_vec    (st_vec),
    .irq       (irq_o)
);

// File: tb/test_irq_slice_bank.sv
module test_irq_slice_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_shift = '0;
    logic [15:0] evt_swap  = '0;
    logic [15:0] evt_match = '0;
    logic [15:0] evt_bitm  = '0;
    logic [4:0]  addr  = '0;
    logic        wr    = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_slice_bank i_irq_slice_bank (
        .clk_i       (clk),
        .rst_i       (rst),
        .evt_shift_i (evt_shift),
        .evt_swap_i  (evt_swap),
        .evt_match_i (evt_match),
        .evt_bitm_i  (evt_bitm),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [4:0] ra(input int cls, input int slot);
        return 5'(cls * 8 + slot);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input int cls, input int slot, input logic [15:0] d);
        @(negedge clk);
        addr = ra(cls, slot); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input string req, input int cls, input int slot, input logic [15:0] exp);
        addr = ra(cls, slot);
        #1;
        check(req, rdata, exp);
    endtask

    task automatic t_reset_state;
        for (int c = 0; c < 4; c++) begin
            reg_read("R1 enable after reset", c, 2, 16'h0000);
            reg_read("R1 pending after reset", c, 3, 16'h0000);
        end
        check("R1 irq after reset", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_enable_regs;
        reg_write(1, 0, 16'h0009);
        reg_read("R2 R4 enable set slices 0 and 3", 1, 2, 16'h0009);
        reg_write(1, 0, 16'h0100);
        reg_read("R2 zero bits untouched by set", 1, 2, 16'h0109);
        reg_write(1, 1, 16'h0001);
        reg_read("R3 clear one bit", 1, 2, 16'h0108);
        reg_write(1, 1, 16'h0108);
        reg_read("R3 clear rest", 1, 2, 16'h0000);
    endtask

    task automatic t_event_latch;
        @(negedge clk);
        evt_match = 16'h8421;
        @(negedge clk);
        evt_match = '0;
        reg_read("R5 several bits latch while disabled", 2, 3, 16'h8421);
        check("R9 no irq when disabled", {15'b0, irq}, 16'h0000);
        reg_write(2, 0, 16'h0010);
        #1;
        check("R9 no irq without overlap", {15'b0, irq}, 16'h0000);
        reg_write(2, 0, 16'h0001);
        #1;
        check("R9 irq when pending bit enabled", {15'b0, irq}, 16'h0001);
        reg_write(2, 5, 16'h0001);
        reg_read("R7 acknowledge one bit", 2, 3, 16'h8420);
        check("R9 irq drops after ack", {15'b0, irq}, 16'h0000);
        repeat (5) @(negedge clk);
        reg_read("R5 pending holds", 2, 3, 16'h8420);
        reg_write(2, 5, 16'hFFFF);
        reg_write(2, 1, 16'hFFFF);
    endtask

    task automatic t_force_and_isolation;
        reg_write(3, 4, 16'h4000);
        reg_read("R6 force sets pending", 3, 3, 16'h4000);
        reg_read("R10 class 0 pending untouched", 0, 3, 16'h0000);
        reg_read("R10 class 2 pending untouched", 2, 3, 16'h0000);
        reg_write(0, 0, 16'h4000);
        reg_read("R10 class 3 enable untouched", 3, 2, 16'h0000);
        check("R10 no cross-class irq", {15'b0, irq}, 16'h0000);
        reg_write(3, 0, 16'h4000);
        #1;
        check("R9 irq from class 3", {15'b0, irq}, 16'h0001);
        reg_write(3, 5, 16'h4000);
        reg_write(3, 1, 16'h4000);
        reg_write(0, 1, 16'h4000);
        #1;
        check("R9 irq low after cleanup", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_collision;
        reg_write(0, 4, 16'h0003);
        @(negedge clk);
        evt_shift = 16'h0001;
        addr = ra(0, 5); wdata = 16'h0003; wr = 1'b1;
        @(negedge clk);
        evt_shift = '0; wr = 1'b0; wdata = '0;
        reg_read("R8 event beats acknowledge", 0, 3, 16'h0001);
        reg_write(0, 5, 16'h0001);
        reg_read("R7 final ack", 0, 3, 16'h0000);
    endtask

    task automatic t_unmapped;
        reg_write(1, 0, 16'h00F0);
        reg_write(1, 4, 16'h0F00);
        reg_write(1, 6, 16'hFFFF);
        reg_write(1, 7, 16'hFFFF);
        reg_read("R11 enable unchanged by slot 6/7", 1, 2, 16'h00F0);
        reg_read("R11 pending unchanged by slot 6/7", 1, 3, 16'h0F00);
        reg_read("R11 slot 0 reads zero", 1, 0, 16'h0000);
        reg_read("R11 slot 1 reads zero", 1, 1, 16'h0000);
        reg_read("R11 slot 4 reads zero", 1, 4, 16'h0000);
        reg_read("R11 slot 5 reads zero", 1, 5, 16'h0000);
        reg_read("R11 slot 6 reads zero", 1, 6, 16'h0000);
        reg_read("R11 slot 7 reads zero", 1, 7, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_enable_regs();
        t_event_latch();
        t_force_and_isolation();
        t_collision();
        t_unmapped();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule